// File: doc/BRIEF.md
# Ordered Store Buffer with Load Forwarding

This block sits between a simple in-order core and a memory write port. Stores from the core are captured in a small circular queue in one cycle, so the core can move on at once. A handshake on the memory side then drains the queue one entry at a time, oldest first. Memory therefore sees the stores in the order the core issued them.

Loads look at the buffered stores first. If one or more pending stores target the load address, the newest of them supplies the data. If none does, the load reads memory directly through a combinational read port, ahead of older pending stores to other addresses. This store-then-load reordering is the only one allowed, and it gives total store ordering. A fence input holds the core back until every buffered store has reached memory. Load results return one cycle after the load is accepted.

Top module: `tso_store_buffer`

## Requirements
- R1: After synchronous reset the buffer is empty: `mem_wr_valid` is 0, `st_ready` is 1, `core_stall` is 0 and `ld_rsp_valid` is 0.
- R2: A store with `st_valid` high and `st_ready` high is captured at that clock edge. The core may issue another store in the very next cycle.
- R3: `st_ready` is low when the buffer holds DEPTH entries and no entry drains in that cycle. When the buffer is full and an entry drains in the same cycle, a store is still accepted.
- R4: `mem_wr_valid` is high exactly when the buffer is non-empty. `mem_wr_addr` and `mem_wr_data` show the oldest entry and stay steady until `mem_wr_ready` is high. Memory receives the stores in issue order, one per handshake.
- R5: A load whose word address matches one or more buffered entries returns the data of the youngest matching entry.
- R6: A load with no matching buffered entry returns `mem_rd_data`. `mem_rd_addr` equals `ld_addr` in the same cycle.
- R7: An accepted load produces `ld_rsp_valid` high with its data exactly one cycle later. In cycles with no accepted load, `ld_rsp_valid` is low.
- R8: While `fence_req` is high and the buffer is not empty, `core_stall` is high and `st_ready` is low. Stores and loads presented in those cycles are ignored and produce no buffer entry and no response.
- R9: A load searches only the entries held before the current edge. A store accepted in the same cycle is not forwarded to that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Core presents a store |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| st_ready | output | 1 | Store can be accepted this cycle |
| ld_valid | input | 1 | Core presents a load |
| ld_addr | input | 32 | Load address |
| ld_rsp_valid | output | 1 | Load result valid (one cycle after acceptance) |
| ld_rsp_data | output | 32 | Load result |
| fence_req | input | 1 | Core requests that all buffered stores be written to memory |
| core_stall | output | 1 | Core must hold: fence pending with buffered stores |
| mem_rd_addr | output | 32 | Direct memory read address |
| mem_rd_data | input | 32 | Direct memory read data (combinational) |
| mem_wr_valid | output | 1 | Oldest buffered store is offered to memory |
| mem_wr_addr | output | 32 | Address of the offered store |
| mem_wr_data | output | 32 | Data of the offered store |
| mem_wr_ready | input | 1 | Memory takes the offered store this cycle |

## Verification
A head or tail pointer that slips shows up as a wrong address or data on the drain port the next time that slot reaches the head. The bench compares every drained entry with a program-order queue in the same cycle. An occupancy count that is off shows up within one cycle as `st_ready` or `mem_wr_valid` disagreeing with the model's buffer size. A faulty age search shows up as the wrong value in the very next load response to an address that has several pending stores. After a final full drain, the memory contents are compared word by word with the program-order image.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 32;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } sb_entry_t;

    function automatic logic same_word(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] b);
        return a[ADDR_W-1:2] == b[ADDR_W-1:2];
    endfunction

endpackage

// File: rtl/sb_storage.sv
module sb_storage
    import sb_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  sb_entry_t        push_entry,
    input  logic             pop,
    output sb_entry_t        slots [DEPTH],
    output logic [DEPTH-1:0] slot_vld,
    output logic [IDX_W-1:0] head,
    output logic [CNT_W-1:0] count,
    output sb_entry_t        head_entry
);

    sb_entry_t        entry_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;

    function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            entry_q[tail_q] <= push_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            vld_q   <= '0;
        end else begin
            if (pop) begin
                vld_q[head_q] <= 1'b0;
                head_q        <= step_idx(head_q);
            end
            if (push) begin
                vld_q[tail_q] <= 1'b1;
                tail_q        <= step_idx(tail_q);
            end
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign slots      = entry_q;
    assign slot_vld   = vld_q;
    assign head       = head_q;
    assign count      = count_q;
    assign head_entry = entry_q[head_q];

endmodule

// File: rtl/sb_forward.sv
module sb_forward
    import sb_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  sb_entry_t         slots [DEPTH],
    input  logic [DEPTH-1:0]  slot_vld,
    input  logic [IDX_W-1:0]  head,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data
);

    // Walk from oldest (head) to newest; a later match overrides an earlier one.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < int'(DEPTH); k++) begin
            int s;
            s = int'(head) + k;
            if (s >= int'(DEPTH)) s = s - int'(DEPTH);
            if (slot_vld[IDX_W'(s)] && same_word(slots[IDX_W'(s)].addr, lookup_addr)) begin
                hit      = 1'b1;
                hit_data = slots[IDX_W'(s)].data;
            end
        end
    end

endmodule

// File: rtl/sb_core_gate.sv
module sb_core_gate (
    input  logic st_valid,
    input  logic ld_valid,
    input  logic fence_req,
    input  logic empty,
    input  logic full,
    input  logic draining,
    output logic core_stall,
    output logic st_ready,
    output logic st_take,
    output logic ld_take
);

    always_comb begin
        core_stall = fence_req && !empty;
        st_ready   = !core_stall && (!full || draining);
        st_take    = st_valid && st_ready;
        ld_take    = ld_valid && !core_stall;
    end

endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer
    import sb_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    input  logic [31:0]       st_addr,
    input  logic [31:0]       st_data,
    output logic              st_ready,
    input  logic              ld_valid,
    input  logic [31:0]       ld_addr,
    output logic              ld_rsp_valid,
    output logic [31:0]       ld_rsp_data,
    input  logic              fence_req,
    output logic              core_stall,
    output logic [31:0]       mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    output logic              mem_wr_valid,
    output logic [31:0]       mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    input  logic              mem_wr_ready
);

    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    sb_entry_t        slots [DEPTH];
    logic [DEPTH-1:0] slot_vld;
    logic [IDX_W-1:0] head;
    logic [CNT_W-1:0] occ;
    sb_entry_t        head_entry;
    sb_entry_t        new_entry;

    logic empty, full, draining, st_take, ld_take;
    logic fwd_hit;
    logic [DATA_W-1:0] fwd_data;
    logic              rsp_vld_q;
    logic [DATA_W-1:0] rsp_data_q;

    assign empty    = (occ == '0);
    assign full     = (occ == CNT_W'(DEPTH));
    assign draining = !empty && mem_wr_ready;

    assign new_entry.addr = st_addr;
    assign new_entry.data = st_data;

    sb_core_gate u_gate (
        .st_valid   (st_valid),
        .ld_valid   (ld_valid),
        .fence_req  (fence_req),
        .empty      (empty),
        .full       (full),
        .draining   (draining),
        .core_stall (core_stall),
        .st_ready   (st_ready),
        .st_take    (st_take),
        .ld_take    (ld_take)
    );

    sb_storage #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push       (st_take),
        .push_entry (new_entry),
        .pop        (draining),
        .slots      (slots),
        .slot_vld   (slot_vld),
        .head       (head),
        .count      (occ),
        .head_entry (head_entry)
    );

    sb_forward #(.DEPTH(DEPTH)) u_fwd (
        .slots       (slots),
        .slot_vld    (slot_vld),
        .head        (head),
        .lookup_addr (ld_addr),
        .hit         (fwd_hit),
        .hit_data    (fwd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld_q  <= 1'b0;
            rsp_data_q <= '0;
        end else begin
            rsp_vld_q <= ld_take;
            if (ld_take) begin
                rsp_data_q <= fwd_hit ? fwd_data : mem_rd_data;
            end
        end
    end

    assign ld_rsp_valid = rsp_vld_q;
    assign ld_rsp_data  = rsp_data_q;
    assign mem_rd_addr  = ld_addr;
    assign mem_wr_valid = !empty;
    assign mem_wr_addr  = head_entry.addr;
    assign mem_wr_data  = head_entry.data;

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             st_valid,
    input logic             st_ready,
    input logic             ld_valid,
    input logic             ld_rsp_valid,
    input logic             fence_req,
    input logic             core_stall,
    input logic             mem_wr_valid,
    input logic             mem_wr_ready,
    input logic [31:0]      mem_wr_addr,
    input logic [31:0]      mem_wr_data,
    input logic [CNT_W-1:0] occ
);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (occ == CNT_W'(DEPTH) && !(mem_wr_valid && mem_wr_ready)) |-> !st_ready);

    p_store_counted_r2: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_ready && !(mem_wr_valid && mem_wr_ready)) |=> (occ == $past(occ) + 1'b1));

    p_drain_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    p_empty_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> !mem_wr_valid);

    p_fence_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (fence_req && mem_wr_valid) |-> (core_stall && !st_ready));

    p_load_rsp_r7: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !core_stall) |=> ld_rsp_valid);

    p_no_spurious_rsp_r7: assert property (@(posedge clk) disable iff (rst)
        !(ld_valid && !core_stall) |=> !ld_rsp_valid);

endmodule

bind tso_store_buffer sb_checker #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .st_valid     (st_valid),
    .st_ready     (st_ready),
    .ld_valid     (ld_valid),
    .ld_rsp_valid (ld_rsp_valid),
    .fence_req    (fence_req),
    .core_stall   (core_stall),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .occ          (occ)
);

// File: tb/tb_tso_store_buffer.sv
`timescale 1ns/1ps
module tb_tso_store_buffer;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        st_valid, ld_valid, fence_req, mem_wr_ready;
    logic [31:0] st_addr, st_data, ld_addr;
    logic        st_ready, ld_rsp_valid, core_stall, mem_wr_valid;
    logic [31:0] ld_rsp_data, mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;

    logic [31:0] bmem      [64];
    logic [31:0] model_mem [64];

    typedef struct { logic [31:0] a; logic [31:0] d; } st_t;
    typedef struct { logic [31:0] d; string tag; } rsp_t;
    st_t  ref_q [$];
    rsp_t exp_q [$];

    int    checks = 0;
    int    errors = 0;
    int    cyc    = 0;
    bit    done   = 0;
    string force_tag = "";

    always #2 clk = ~clk;

    assign mem_rd_data = bmem[mem_rd_addr[7:2]];

    tso_store_buffer #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
        .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
        .fence_req(fence_req), .core_stall(core_stall),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_ready(mem_wr_ready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Monitor: pop expected load results as the design produces them (R7, R5, R6, R9)
    always @(negedge clk) begin
        if (!rst && ld_rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R7 unexpected response", ld_rsp_data, 32'h0);
            end else begin
                rsp_t e;
                e = exp_q.pop_front();
                chk(ld_rsp_data === e.d, e.tag, ld_rsp_data, e.d);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            chk(0, "watchdog", 32'(cyc), 32'h0);
            finish_run();
        end
    end

    // Driver: one core/memory cycle, inputs applied at negedge, model committed at the edge
    task automatic step(input bit sv, input logic [31:0] sa, input logic [31:0] sd,
                        input bit lv, input logic [31:0] la, input bit fen, input bit rdy);
        int   sz;
        bit   stall_e, drain_e, ready_e, fwd;
        logic [31:0] ev;
        st_valid = sv; st_addr = sa; st_data = sd;
        ld_valid = lv; ld_addr = la; fence_req = fen; mem_wr_ready = rdy;
        #1;
        sz      = ref_q.size();
        stall_e = fen && (sz != 0);
        drain_e = (sz != 0) && rdy;
        ready_e = !stall_e && ((sz < DEPTH) || drain_e);
        chk(core_stall == stall_e, "R8 core_stall", 32'(core_stall), 32'(stall_e));
        chk(mem_wr_valid == (sz != 0), "R4 mem_wr_valid", 32'(mem_wr_valid), 32'(sz != 0));
        chk(st_ready == ready_e, "R3 st_ready", 32'(st_ready), 32'(ready_e));
        if (lv) chk(mem_rd_addr == la, "R6 mem_rd_addr", mem_rd_addr, la);
        if (drain_e) begin
            chk(mem_wr_addr == ref_q[0].a, "R4 drain addr", mem_wr_addr, ref_q[0].a);
            chk(mem_wr_data == ref_q[0].d, "R4 drain data", mem_wr_data, ref_q[0].d);
        end
        if (lv && !stall_e) begin
            fwd = 0;
            ev  = bmem[la[7:2]];
            foreach (ref_q[i]) if (ref_q[i].a[31:2] == la[31:2]) begin fwd = 1; ev = ref_q[i].d; end
            exp_q.push_back('{ev, (force_tag != "") ? force_tag : (fwd ? "R5 forward" : "R6 memory")});
        end
        if (sv && ready_e) ref_q.push_back('{sa, sd});
        @(posedge clk);
        if (mem_wr_valid && rdy) bmem[mem_wr_addr[7:2]] = mem_wr_data;
        if (drain_e) begin
            model_mem[ref_q[0].a[7:2]] = ref_q[0].d;
            void'(ref_q.pop_front());
        end
        @(negedge clk);
    endtask

    task automatic idle(input bit rdy);
        step(0, 0, 0, 0, 0, 0, rdy);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            bmem[i]      = 32'hA000_0000 + 32'(i);
            model_mem[i] = 32'hA000_0000 + 32'(i);
        end
        rst = 1; st_valid = 0; ld_valid = 0; fence_req = 0; mem_wr_ready = 0;
        st_addr = 0; st_data = 0; ld_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        chk(st_ready == 1,     "R1 st_ready",     32'(st_ready), 1);
        chk(mem_wr_valid == 0, "R1 mem_wr_valid", 32'(mem_wr_valid), 0);
        chk(core_stall == 0,   "R1 core_stall",   32'(core_stall), 0);
        chk(ld_rsp_valid == 0, "R1 ld_rsp_valid", 32'(ld_rsp_valid), 0);

        // R2: back-to-back stores, memory not ready
        step(1, 32'h10, 32'h11, 0, 0, 0, 0);
        step(1, 32'h10, 32'h22, 0, 0, 0, 0);
        chk(mem_wr_valid == 1 && mem_wr_addr == 32'h10, "R2 store captured", mem_wr_addr, 32'h10);

        // R5: youngest of two matches; R6: no match reads memory; R7 timing
        step(0, 0, 0, 1, 32'h10, 0, 0);
        chk(ld_rsp_valid == 1, "R7 rsp next cycle", 32'(ld_rsp_valid), 1);
        step(0, 0, 0, 1, 32'h14, 0, 0);
        idle(0);
        chk(ld_rsp_valid == 0, "R7 no rsp without load", 32'(ld_rsp_valid), 0);

        // R9: same-cycle store and load to the same address are not forwarded
        force_tag = "R9 same-cycle store not forwarded";
        step(1, 32'h18, 32'h33, 1, 32'h18, 0, 0);
        force_tag = "";
        step(0, 0, 0, 1, 32'h18, 0, 0);

        // R3: fill to DEPTH, then a store is refused; accepted when drain coincides
        while (ref_q.size() < DEPTH) step(1, 32'h20 + 32'(ref_q.size()*4), 32'hB0 + 32'(ref_q.size()), 0, 0, 0, 0);
        step(1, 32'h3C, 32'hDEAD, 0, 0, 0, 0);
        chk(ref_q.size() == DEPTH, "R3 full refused", 32'(ref_q.size()), DEPTH);
        step(1, 32'h3C, 32'hBEEF, 0, 0, 0, 1);
        chk(ref_q.size() == DEPTH, "R3 accept with drain", 32'(ref_q.size()), DEPTH);

        // R4: drain with a stuttering ready
        for (int i = 0; i < 20; i++) idle(i % 3 != 0);

        // R8: fence with pending stores; store and load ignored during stall
        while (ref_q.size() < 3) step(1, 32'h40 + 32'(ref_q.size()*4), 32'hC0 + 32'(ref_q.size()), 0, 0, 0, 0);
        step(1, 32'h50, 32'hBAD0, 1, 32'h40, 1, 0);
        step(1, 32'h54, 32'hBAD1, 1, 32'h44, 1, 0);
        chk(ld_rsp_valid == 0, "R8 load ignored", 32'(ld_rsp_valid), 0);
        while (ref_q.size() != 0) step(0, 0, 0, 0, 0, 1, 1);
        step(1, 32'h50, 32'h50, 0, 0, 1, 0);
        chk(mem_wr_valid == 1 && mem_wr_data == 32'h50, "R8 fence released", mem_wr_data, 32'h50);
        idle(1);
        chk(bmem[20] == 32'h50, "R8 ignored store absent", bmem[20], 32'h50);

        // Mixed random traffic over a small address set to force matches
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], {26'd0, r[4:2], 2'b00}, $urandom, r[5], {26'd0, r[8:6], 2'b00},
                 (r[12:9] == 0), r[13] | r[14]);
        end

        // Final drain and memory image compare
        while (ref_q.size() != 0) idle(1);
        idle(1); idle(1);
        for (int i = 0; i < 64; i++)
            if (bmem[i] !== model_mem[i]) chk(0, "R4 final memory", bmem[i], model_mem[i]);
        chk(1, "R4 final memory", 0, 0);
        chk(exp_q.size() == 0, "R7 all loads answered", 32'(exp_q.size()), 0);
        finish_run();
    end

endmodule